// File: doc/BRIEF.md
# Monitor Channel Transmit Register Controller

This block is the processor-side register bank for a group of serial ports (four by default). Each port owns a 16-bit transmit control word holding an outgoing byte, a ready flag and a last flag. The bank forwards each request to that port's frame transmitter over a request/acknowledge pair. A plain byte request offers the stored byte. An end-of-message request offers the fill value 0xFF together with an end-of-message marker. When the transmitter acknowledges a request, the controller clears the flags itself.

Each port also has a receive word. A strobe from the frame receiver loads it with the incoming byte and sets a change flag. The processor clears that flag by reading the word. Per-port interrupt lines signal a finished transmission and an unread received byte. Each line has its own enable bit. A transmit completion stays pending in a status word until the processor writes a one to clear it.

Top module: `mon_tx_regs`

## Requirements
- R1: A transmit word holds the byte in bits 7:0, ready in bit 8 and last in bit 9. Bits 15:10 always read as zero, and writing them has no effect.
- R2: Hardware reset `rst` clears every register and output. Software reset `sw_rst` clears every transmit word, which withdraws any open request.
- R3: A write that sets ready on an idle port raises `tx_req` for that port from the next clock, with the written byte on `tx_data` and `tx_eom` low. The request holds until `tx_ack`, and the clock edge that samples `tx_ack` clears ready.
- R4: While a port's request is open, a write to its transmit word changes only the byte. The ready and last bits are left unchanged, and the open request is neither restarted nor turned into an end-of-message.
- R5: When ready and last are both set, the port shows `tx_eom` high and `tx_data` = 0xFF, whatever byte is stored. The acknowledge clears ready and last together and leaves the stored byte in place.
- R6: Last written without ready raises no request and no end-of-message.
- R7: Each acknowledge of an open request sets that port's bit in the status word (byte offset 18, bits 3:0 = ports 0..3). An acknowledge with no open request changes nothing.
- R8: `irq_tx` for a port equals its status bit ANDed with its transmit enable (enable word at offset 16, bits 3:0), one clock later. A status bit stays set until a write of one to it. Writing zero leaves it set.
- R9: A `rx_valid` strobe loads the port's receive word (offsets 8, 10, 12, 14) with the byte in bits 7:0 and sets the change flag in bit 8. `irq_rx` equals the change flag ANDed with the receive enable (enable word bits 7:4), one clock later.
- R10: Reading a receive word clears its change flag, which drops `irq_rx`. If a new byte arrives on the same clock as the read, the read returns the old contents and the flag stays set.
- R11: The transmit words sit at byte offsets 0, 2, 4 and 6, one per port in port order. A read returns the addressed word on `cpu_rdata` at the clock edge that samples `cpu_rd`. `cpu_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the transmit words |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 5 | Byte address of the register |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| tx_req | output | 4 | Per-port transmit request |
| tx_eom | output | 4 | Per-port end-of-message marker |
| tx_data | output | 32 | Per-port byte to send, port n in bits 8n+7:8n |
| tx_ack | input | 4 | Per-port acknowledge from the frame transmitter |
| rx_valid | input | 4 | Per-port strobe for a received byte |
| rx_data | input | 32 | Per-port received byte, port n in bits 8n+7:8n |
| irq_tx | output | 4 | Per-port transmit-done interrupt |
| irq_rx | output | 4 | Per-port received-byte interrupt |

## Verification
Every port is given a series of arithmetically spread bytes. This exposes slice or port-index mistakes in the byte path and in address decoding. The same ports then take end-of-message words whose stored byte is not 0xFF, which separates the forced fill from a plain pass-through. Writes to a port with an open request, last written without ready, and stray acknowledges each show whether the flags follow only their own set and clear conditions. Masked interrupts, and a read that coincides with a new received byte, test enable gating and the set-over-clear priority.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int RDY_BIT = 8;
  localparam int LST_BIT = 9;
  localparam logic [BYTE_W-1:0] EOM_FILL = 8'hFF;

  typedef struct packed {
    logic              last;
    logic              ready;
    logic [BYTE_W-1:0] data;
  } txreg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX,
    SEL_RX,
    SEL_EN,
    SEL_STAT
  } sel_e;
endpackage

// File: rtl/mon_tx_port.sv
module mon_tx_port
  import mon_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_rst,
  input  logic               wr_en,
  input  logic [LST_BIT:0]   wdata,
  input  logic               ack,
  input  logic               clr_done,
  output txreg_t             regs,
  output logic               done,
  output logic               req,
  output logic               eom,
  output logic [BYTE_W-1:0]  byte_out
);
  logic ack_hit;
  assign ack_hit = ack && regs.ready;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      regs <= '0;
    end else begin
      if (ack_hit) begin
        regs.ready <= 1'b0;
        regs.last  <= 1'b0;
      end
      if (wr_en) begin
        regs.data <= wdata[BYTE_W-1:0];
        if (!regs.ready) begin
          regs.ready <= wdata[RDY_BIT];
          regs.last  <= wdata[LST_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done <= 1'b0;
    else if (ack_hit)  done <= 1'b1;
    else if (clr_done) done <= 1'b0;
  end

  assign req      = regs.ready;
  assign eom      = regs.ready && regs.last;
  assign byte_out = eom ? EOM_FILL : regs.data;
endmodule

// File: rtl/mon_rx_port.sv
module mon_rx_port
  import mon_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [BYTE_W-1:0] din,
  input  logic              rd_clr,
  output logic              change,
  output logic [BYTE_W-1:0] rx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      change  <= 1'b0;
      rx_byte <= '0;
    end else if (valid) begin
      change  <= 1'b1;
      rx_byte <= din;
    end else if (rd_clr) begin
      change  <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_tx_regs.sv
module mon_tx_regs
  import mon_tx_pkg::*;
#(
  parameter  int NPORTS = 4,
  localparam int ADDR_W = $clog2(4 * NPORTS + 4)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sw_rst,
  input  logic                       cpu_wr,
  input  logic                       cpu_rd,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [REG_W-1:0]           cpu_wdata,
  output logic [REG_W-1:0]           cpu_rdata,
  output logic [NPORTS-1:0]          tx_req,
  output logic [NPORTS-1:0]          tx_eom,
  output logic [NPORTS*BYTE_W-1:0]   tx_data,
  input  logic [NPORTS-1:0]          tx_ack,
  input  logic [NPORTS-1:0]          rx_valid,
  input  logic [NPORTS*BYTE_W-1:0]   rx_data,
  output logic [NPORTS-1:0]          irq_tx,
  output logic [NPORTS-1:0]          irq_rx
);
  localparam int WIDX_W = ADDR_W - 1;
  localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  // address decode: word index -> region and port
  logic [WIDX_W-1:0] widx, rel;
  logic [PSEL_W-1:0] port;
  sel_e              sel;

  assign widx = cpu_addr[ADDR_W-1:1];

  always_comb begin
    sel  = SEL_NONE;
    rel  = widx;
    if (cpu_addr[0]) begin
      sel = SEL_NONE;
    end else if (widx < WIDX_W'(NPORTS)) begin
      sel = SEL_TX;
    end else if (widx < WIDX_W'(2 * NPORTS)) begin
      sel = SEL_RX;
      rel = widx - WIDX_W'(NPORTS);
    end else if (widx == WIDX_W'(2 * NPORTS)) begin
      sel = SEL_EN;
    end else if (widx == WIDX_W'(2 * NPORTS + 1)) begin
      sel = SEL_STAT;
    end
    port = rel[PSEL_W-1:0];
  end

  // per-port state
  txreg_t              tx_regs [NPORTS];
  logic [NPORTS-1:0]   tx_done, rx_chg;
  logic [BYTE_W-1:0]   rx_bytes [NPORTS];
  logic [NPORTS-1:0]   tx_wr, clr_done, rd_clr;
  logic [2*NPORTS-1:0] irq_en;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign tx_wr[i]    = cpu_wr && (sel == SEL_TX) && (port == PSEL_W'(i));
    assign clr_done[i] = cpu_wr && (sel == SEL_STAT) && cpu_wdata[i];
    assign rd_clr[i]   = cpu_rd && (sel == SEL_RX) && (port == PSEL_W'(i));

    mon_tx_port u_tx (
      .clk      (clk),
      .rst      (rst),
      .sw_rst   (sw_rst),
      .wr_en    (tx_wr[i]),
      .wdata    (cpu_wdata[LST_BIT:0]),
      .ack      (tx_ack[i]),
      .clr_done (clr_done[i]),
      .regs     (tx_regs[i]),
      .done     (tx_done[i]),
      .req      (tx_req[i]),
      .eom      (tx_eom[i]),
      .byte_out (tx_data[i*BYTE_W +: BYTE_W])
    );

    mon_rx_port u_rx (
      .clk     (clk),
      .rst     (rst),
      .valid   (rx_valid[i]),
      .din     (rx_data[i*BYTE_W +: BYTE_W]),
      .rd_clr  (rd_clr[i]),
      .change  (rx_chg[i]),
      .rx_byte (rx_bytes[i])
    );
  end

  // interrupt enables and registered interrupt lines
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= '0;
    end else if (cpu_wr && sel == SEL_EN) begin
      irq_en <= cpu_wdata[2*NPORTS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx <= '0;
      irq_rx <= '0;
    end else begin
      irq_tx <= tx_done & irq_en[NPORTS-1:0];
      irq_rx <= rx_chg & irq_en[2*NPORTS-1:NPORTS];
    end
  end

  // registered read path
  logic [REG_W-1:0] rd_next;

  always_comb begin
    unique case (sel)
      SEL_TX:   rd_next = REG_W'(tx_regs[port]);
      SEL_RX:   rd_next = REG_W'({rx_chg[port], rx_bytes[port]});
      SEL_EN:   rd_next = REG_W'(irq_en);
      SEL_STAT: rd_next = REG_W'(tx_done);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_next;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = &{1'b0, cpu_wdata[REG_W-1:LST_BIT+1]};
endmodule

// File: rtl/mon_tx_regs_chk.sv
module mon_tx_regs_chk
  import mon_tx_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sw_rst,
  input logic [NPORTS-1:0]        tx_req,
  input logic [NPORTS-1:0]        tx_eom,
  input logic [NPORTS*BYTE_W-1:0] tx_data,
  input logic [NPORTS-1:0]        tx_ack,
  input logic [NPORTS-1:0]        irq_tx,
  input logic [NPORTS-1:0]        irq_rx
);
  // R2: reset leaves no request and no interrupt
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (tx_req == '0 && irq_tx == '0 && irq_rx == '0));

  // R3: an acknowledged request is gone on the next cycle
  a_r3_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    ((tx_req & tx_ack) != '0) |=> ((tx_req & $past(tx_req & tx_ack)) == '0));

  // R4: an open request is held until acknowledged
  a_r4_req_holds: assert property (@(posedge clk) disable iff (rst || sw_rst)
    ((tx_req & ~tx_ack) != '0) |=> (($past(tx_req & ~tx_ack) & ~tx_req) == '0));

  // R5: end-of-message always comes with a request and the fill byte
  for (genvar i = 0; i < NPORTS; i++) begin : g_eom
    a_r5_eom_fill: assert property (@(posedge clk) disable iff (rst)
      tx_eom[i] |-> (tx_req[i] && tx_data[i*BYTE_W +: BYTE_W] == EOM_FILL));
  end
endmodule

bind mon_tx_regs mon_tx_regs_chk #(.NPORTS(NPORTS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sw_rst  (sw_rst),
  .tx_req  (tx_req),
  .tx_eom  (tx_eom),
  .tx_data (tx_data),
  .tx_ack  (tx_ack),
  .irq_tx  (irq_tx),
  .irq_rx  (irq_rx)
);

// File: tb/mon_tx_regs_test.sv
`timescale 1ns/1ps
module mon_tx_regs_test;
  logic        clk = 1'b0;
  logic        rst, sw_rst, cpu_wr, cpu_rd;
  logic [4:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [3:0]  tx_req, tx_eom, tx_ack, rx_valid, irq_tx, irq_rx;
  logic [31:0] tx_data, rx_data;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mon_tx_regs uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_req(tx_req), .tx_eom(tx_eom), .tx_data(tx_data), .tx_ack(tx_ack),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    cpu_rd = 1'b1; cpu_addr = a;
    tick();
    cpu_rd = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic ack(int p);
    tx_ack[p] = 1'b1;
    tick();
    tx_ack = '0;
  endtask

  task automatic rx(int p, logic [7:0] b);
    rx_valid[p] = 1'b1; rx_data[p*8 +: 8] = b;
    tick();
    rx_valid = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst = 1'b1; sw_rst = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; tx_ack = '0; rx_valid = '0; rx_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    chk("R2 reset tx_req", 32'(tx_req), 32'h0);
    chk("R2 reset irq", 32'({irq_tx, irq_rx}), 32'h0);
    for (int p = 0; p < 4; p++) begin
      rd(5'(2 * p), v);
      chk("R2 reset tx word", 32'(v), 32'h0);
    end

    wr(5'd16, 16'h00FF);
    rd(5'd16, v);
    chk("R11 enable readback", 32'(v), 32'h00FF);

    // byte sweep across every port
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] d;
        d = 8'(p * 37 + k * 29 + 5);
        wr(5'(2 * p), 16'h0100 | 16'(d));
        chk("R3 req", 32'(tx_req), 32'(1 << p));
        chk("R3 data", 32'(tx_data[p*8 +: 8]), 32'(d));
        chk("R3 eom low", 32'(tx_eom), 32'h0);
        rd(5'(2 * p), v);
        chk("R11 tx word", 32'(v), 32'(16'h0100 | 16'(d)));
        ack(p);
        chk("R3 ack clears", 32'(tx_req), 32'h0);
        tick();
        chk("R8 irq_tx", 32'(irq_tx), 32'(1 << p));
        rd(5'd18, v);
        chk("R7 status", 32'(v), 32'(1 << p));
        wr(5'd18, 16'h0000);
        tick();
        chk("R8 write zero keeps", 32'(irq_tx), 32'(1 << p));
        wr(5'd18, 16'(1 << p));
        tick();
        chk("R8 w1c", 32'(irq_tx), 32'h0);
        rd(5'(2 * p), v);
        chk("R1 byte kept, ready clear", 32'(v), 32'(d));
      end
    end

    // end-of-message on each port
    for (int p = 0; p < 4; p++) begin
      wr(5'(2 * p), 16'h033C);
      chk("R5 eom", 32'(tx_eom), 32'(1 << p));
      chk("R5 fill", 32'(tx_data[p*8 +: 8]), 32'hFF);
      ack(p);
      rd(5'(2 * p), v);
      chk("R5 both cleared", 32'(v), 32'h003C);
      chk("R5 eom gone", 32'(tx_eom), 32'h0);
      wr(5'd18, 16'h000F);
    end

    // write while pending
    wr(5'd2, 16'h0111);
    wr(5'd2, 16'h0322);
    chk("R4 no eom", 32'(tx_eom), 32'h0);
    chk("R4 data updated", 32'(tx_data[15:8]), 32'h22);
    rd(5'd2, v);
    chk("R4 flags kept", 32'(v), 32'h0122);
    wr(5'd2, 16'h0033);
    chk("R4 req held", 32'(tx_req), 32'h2);
    rd(5'd2, v);
    chk("R4 ready kept", 32'(v), 32'h0133);
    ack(1);
    wr(5'd18, 16'h000F);

    // last without ready, software reset
    wr(5'd4, 16'h0244);
    chk("R6 no req", 32'({tx_req, tx_eom}), 32'h0);
    rd(5'd4, v);
    chk("R6 word", 32'(v), 32'h0244);
    wr(5'd6, 16'h0155);
    chk("R3 port3 req", 32'(tx_req), 32'h8);
    sw_rst = 1'b1; tick(); sw_rst = 1'b0;
    chk("R2 sw reset req", 32'(tx_req), 32'h0);
    rd(5'd4, v);
    chk("R2 sw reset word", 32'(v), 32'h0);

    // reserved bits
    wr(5'd0, 16'hFC5A);
    rd(5'd0, v);
    chk("R1 reserved", 32'(v), 32'h005A);

    // stray acknowledges
    tx_ack = 4'hF; tick(); tx_ack = '0;
    tick();
    rd(5'd18, v);
    chk("R7 stray ack status", 32'(v), 32'h0);
    chk("R7 stray ack irq", 32'(irq_tx), 32'h0);

    // masked transmit interrupt
    wr(5'd16, 16'h00F0);
    wr(5'd6, 16'h0101);
    ack(3);
    tick();
    chk("R8 masked", 32'(irq_tx), 32'h0);
    rd(5'd18, v);
    chk("R7 status masked", 32'(v), 32'h8);
    wr(5'd16, 16'h00F8);
    tick();
    chk("R8 unmask pending", 32'(irq_tx), 32'h8);
    wr(5'd18, 16'h0008);

    // receive path
    for (int p = 0; p < 4; p++) begin
      logic [7:0] b;
      b = 8'(p * 53 + 17);
      rx(p, b);
      tick();
      chk("R9 irq_rx", 32'(irq_rx), 32'(1 << p));
      rd(5'(8 + 2 * p), v);
      chk("R9 rx word", 32'(v), 32'(16'h0100 | 16'(b)));
      tick();
      chk("R10 irq cleared", 32'(irq_rx), 32'h0);
      rd(5'(8 + 2 * p), v);
      chk("R10 flag cleared", 32'(v), 32'(b));
    end

    // read collides with new byte
    rx(0, 8'h66);
    cpu_rd = 1'b1; cpu_addr = 5'd8; rx_valid[0] = 1'b1; rx_data[7:0] = 8'h77;
    tick();
    cpu_rd = 1'b0; rx_valid = '0;
    chk("R10 collide old", 32'(cpu_rdata), 32'h0166);
    rd(5'd8, v);
    chk("R10 collide flag kept", 32'(v), 32'h0177);

    // masked receive interrupt
    wr(5'd16, 16'h000F);
    rx(2, 8'h99);
    tick();
    chk("R9 rx masked", 32'(irq_rx), 32'h0);
    rd(5'd12, v);
    chk("R9 masked word", 32'(v), 32'h0199);

    finish_run();
  end
endmodule